// File: doc/BRIEF.md
# External Data Bus Cycle Sequencer

This block drives the strobes of a multiplexed 8-bit external data bus for a small microcontroller core. It runs on the oscillator clock, so one clock is one oscillator period. A free-running phase counter splits time into machine cycles of twelve clocks: six states of two phases each, with phase indices 0 to 11. A read or write request carries a 16-bit address and, for a write, one data byte. The request is held until the next machine-cycle boundary. The block then runs one full bus cycle: an address-latch pulse with the low address byte on the shared bus, a gap, a six-clock read or write strobe, and a one-clock done pulse. The high address byte is driven on its own pins for the whole cycle.

The shared bus is split into an output byte with an enable and an input byte, so no port of the block is bidirectional. The block captures read data from the input byte partway through the read strobe and holds it on `rdata_o`. A general-purpose port runs on the same phase grid in every machine cycle, busy or not. Its input pins are sampled in one fixed phase. Values written to its output register reach the pins only at the end of the cycle.

The state machine has five states. IDLE means no bus cycle is running. ADDR covers phases 0 to 2. SETUP covers phases 3 to 4. STROBE covers phases 5 to 10. RECOVER is phase 11. The transitions are:
- start: IDLE to ADDR, at phase 11 with a request pending or arriving.
- addr_done: ADDR to SETUP, at phase 2.
- setup_done: SETUP to STROBE, at phase 4.
- strobe_done: STROBE to RECOVER, at phase 10.
- finish: RECOVER to IDLE.

Top module: `xbus_seq`

## Requirements
- R1: While reset is asserted, `rd_n_o` and `wr_n_o` are 1, `ale_o`, `ad_oe_o`, `addr_hi_oe_o` and `done_o` are 0, and `port_out_o` is 0.
- R2: The phase index starts at 0 on the first clock after reset and advances by one every clock, wrapping from 11 to 0. A bus cycle always occupies phases 0 to 11 of one machine cycle. A request seen on a phase-11 clock starts on the next clock. A request seen in any other phase waits, with the bus idle, for the next phase 0.
- R3: `ale_o` is high in phases 0 and 1 and falls at phase 2. `ad_out_o` carries `addr[7:0]` with `ad_oe_o` high in phases 0 to 2.
- R4: `addr_hi_oe_o` is high and `addr_hi_o` equals `addr[15:8]` in all twelve phases of a bus cycle.
- R5: For a read, `rd_n_o` is low exactly in phases 5 to 10. It falls three clocks after `ale_o` falls and stays low for six clocks.
- R6: For a read, `ad_in_i` is captured at the clock edge that ends phase 8, four clocks after `rd_n_o` falls. `rdata_o` holds that byte from then on. The block does not drive the bus (`ad_oe_o` = 0) in phases 3 to 11 of a read.
- R7: For a write, `wr_n_o` is low exactly in phases 5 to 10.
- R8: For a write, `ad_oe_o` is high and `ad_out_o` carries the write byte in phases 3 to 11. The byte is on the bus at least one clock before `wr_n_o` falls and stays one clock after it rises.
- R9: `rd_n_o` and `wr_n_o` are never low together, and neither is low while `ale_o` is high.
- R10: `done_o` is high for exactly one clock, in phase 11 of a bus cycle, the first clock with the strobe high again.
- R11: A request that arrives while another is pending or while a bus cycle runs is dropped. It changes neither the running cycle nor the cycles after it.
- R12: `port_in_i` is sampled at the clock edge that ends phase 9. `port_sample_o` holds that value until the same edge of the next machine cycle.
- R13: `port_out_o` changes only at the clock edge that ends phase 11. It takes the last value written through `port_we_i`, including a write in that same phase-11 clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-clock request strobe |
| req_we_i | input | 1 | Request is a write (1) or read (0) |
| req_addr_i | input | 16 | Request address |
| req_wdata_i | input | 8 | Write byte |
| ad_in_i | input | 8 | Shared bus input byte |
| ad_out_o | output | 8 | Shared bus output byte (address low or write data) |
| ad_oe_o | output | 1 | Shared bus output enable |
| addr_hi_o | output | 8 | High address byte |
| addr_hi_oe_o | output | 1 | High address output enable |
| ale_o | output | 1 | Address latch pulse |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| rdata_o | output | 8 | Last captured read byte |
| done_o | output | 1 | One-clock completion pulse |
| port_in_i | input | 8 | General-purpose port input pins |
| port_sample_o | output | 8 | Sampled port value |
| port_we_i | input | 1 | Port output write strobe |
| port_wdata_i | input | 8 | Port output write value |
| port_out_o | output | 8 | General-purpose port output pins |

## Verification
Some checks hold on every cycle. The assertions cover strobe exclusion, quiet strobes while the address latch is high, strobes only in phases 5 to 10, write data held around the write strobe, done following the strobe's rise, bus cycles starting only at phase 0, and port output changes only after phase 11. Other behaviour needs specific stimulus and is shown only by the bench's scenarios. This covers the exact placement of each edge within the twelve phases, the captured read byte, how long a request waits for the next boundary, dropped requests, and which phase the port input sampling actually uses.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    localparam int PH_W    = 4;
    localparam int CYC_LEN = 12;

    // Phase indices within a machine cycle (state n phase m -> 2*(n-1)+(m-1)).
    localparam logic [PH_W-1:0] PH_FIRST      = 4'd0;
    localparam logic [PH_W-1:0] PH_ALE_FALL   = 4'd2;
    localparam logic [PH_W-1:0] PH_ADDR_LAST  = 4'd2;
    localparam logic [PH_W-1:0] PH_SETUP_LAST = 4'd4;
    localparam logic [PH_W-1:0] PH_STB_FIRST  = 4'd5;
    localparam logic [PH_W-1:0] PH_CAPTURE    = 4'd8;
    localparam logic [PH_W-1:0] PH_PORT_SMP   = 4'd9;
    localparam logic [PH_W-1:0] PH_STB_LAST   = 4'd10;
    localparam logic [PH_W-1:0] PH_LAST       = 4'd11;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_STROBE,
        ST_RECOVER
    } bus_state_e;

endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen
    import xbus_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase_o,
    output logic            last_o
);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FIRST;
        end else if (phase_q == PH_LAST) begin
            phase_q <= PH_FIRST;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign phase_o = phase_q;
    assign last_o  = (phase_q == PH_LAST);

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (phase_o == PH_FIRST)); // R2

endmodule

// File: rtl/xbus_port_unit.sv
module xbus_port_unit
    import xbus_seq_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   phase_i,
    input  logic [PORT_W-1:0] port_in_i,
    input  logic              port_we_i,
    input  logic [PORT_W-1:0] port_wdata_i,
    output logic [PORT_W-1:0] port_sample_o,
    output logic [PORT_W-1:0] port_out_o
);

    logic [PORT_W-1:0] sample_q;
    logic [PORT_W-1:0] shadow_q;
    logic [PORT_W-1:0] shadow_nx;
    logic [PORT_W-1:0] out_q;

    always_comb begin
        shadow_nx = port_we_i ? port_wdata_i : shadow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= '0;
            shadow_q <= '0;
            out_q    <= '0;
        end else begin
            shadow_q <= shadow_nx;
            if (phase_i == PH_PORT_SMP) begin
                sample_q <= port_in_i;
            end
            if (phase_i == PH_LAST) begin
                out_q <= shadow_nx;
            end
        end
    end

    assign port_sample_o = sample_q;
    assign port_out_o    = out_q;

    AST_PORT_OUT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_out_o) |-> ($past(phase_i) == PH_LAST)); // R13

    AST_PORT_SMP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(port_sample_o) |-> ($past(phase_i) == PH_PORT_SMP)); // R12

endmodule

// File: rtl/xbus_fsm.sv
module xbus_fsm
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PH_W-1:0]      phase_i,
    input  logic                 last_i,
    input  logic                 req_i,
    input  logic                 req_we_i,
    input  logic [ADDR_W-1:0]    req_addr_i,
    input  logic [DATA_W-1:0]    req_wdata_i,
    input  logic [DATA_W-1:0]    ad_in_i,
    output logic                 ale_o,
    output logic                 rd_n_o,
    output logic                 wr_n_o,
    output logic [DATA_W-1:0]    ad_out_o,
    output logic                 ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                 addr_hi_oe_o,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 done_o
);

    localparam int HI_W = ADDR_W - DATA_W;

    bus_state_e state_q, state_d;

    // Pending request slot
    logic              pend_q;
    logic              pend_we_q;
    logic [ADDR_W-1:0] pend_addr_q;
    logic [DATA_W-1:0] pend_wdata_q;

    // Active cycle
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    logic start;
    logic accept;

    assign start  = (state_q == ST_IDLE) && last_i && (pend_q || req_i);
    assign accept = (state_q == ST_IDLE) && !pend_q && req_i && !last_i;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)                     state_d = ST_ADDR;
            ST_ADDR:    if (phase_i == PH_ADDR_LAST)   state_d = ST_SETUP;
            ST_SETUP:   if (phase_i == PH_SETUP_LAST)  state_d = ST_STROBE;
            ST_STROBE:  if (phase_i == PH_STB_LAST)    state_d = ST_RECOVER;
            ST_RECOVER:                                state_d = ST_IDLE;
            default:                                   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request holding and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q       <= 1'b0;
            pend_we_q    <= 1'b0;
            pend_addr_q  <= '0;
            pend_wdata_q <= '0;
            we_q         <= 1'b0;
            addr_q       <= '0;
            wdata_q      <= '0;
            rdata_q      <= '0;
        end else begin
            if (accept) begin
                pend_q       <= 1'b1;
                pend_we_q    <= req_we_i;
                pend_addr_q  <= req_addr_i;
                pend_wdata_q <= req_wdata_i;
            end
            if (start) begin
                pend_q  <= 1'b0;
                we_q    <= pend_q ? pend_we_q    : req_we_i;
                addr_q  <= pend_q ? pend_addr_q  : req_addr_i;
                wdata_q <= pend_q ? pend_wdata_q : req_wdata_i;
            end
            if ((state_q == ST_STROBE) && !we_q && (phase_i == PH_CAPTURE)) begin
                rdata_q <= ad_in_i;
            end
        end
    end

    // Output decode
    always_comb begin
        ale_o        = 1'b0;
        rd_n_o       = 1'b1;
        wr_n_o       = 1'b1;
        ad_oe_o      = 1'b0;
        ad_out_o     = wdata_q;
        addr_hi_oe_o = 1'b1;
        done_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                addr_hi_oe_o = 1'b0;
            end
            ST_ADDR: begin
                ale_o    = (phase_i < PH_ALE_FALL);
                ad_oe_o  = 1'b1;
                ad_out_o = addr_q[DATA_W-1:0];
            end
            ST_SETUP: begin
                ad_oe_o = we_q;
            end
            ST_STROBE: begin
                ad_oe_o = we_q;
                rd_n_o  = we_q;
                wr_n_o  = !we_q;
            end
            ST_RECOVER: begin
                ad_oe_o = we_q;
                done_o  = 1'b1;
            end
            default: begin
                addr_hi_oe_o = 1'b0;
            end
        endcase
    end

    assign addr_hi_o = addr_q[ADDR_W-1 -: HI_W];
    assign rdata_o   = rdata_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o)); // R9

    AST_ALE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> (rd_n_o && wr_n_o)); // R9

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (phase_i >= PH_STB_FIRST && phase_i <= PH_STB_LAST)); // R5

    AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_o |-> (phase_i >= PH_STB_FIRST && phase_i <= PH_STB_LAST)); // R7

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n_o || $rose(wr_n_o)) |-> ad_oe_o); // R8

    AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n_o) || $rose(wr_n_o)) |-> done_o); // R10

    AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hi_oe_o) |-> (phase_i == PH_FIRST)); // R2

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int PORT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_i,
    input  logic                     req_we_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic [DATA_W-1:0]        ad_in_i,
    output logic [DATA_W-1:0]        ad_out_o,
    output logic                     ad_oe_o,
    output logic [ADDR_W-DATA_W-1:0] addr_hi_o,
    output logic                     addr_hi_oe_o,
    output logic                     ale_o,
    output logic                     rd_n_o,
    output logic                     wr_n_o,
    output logic [DATA_W-1:0]        rdata_o,
    output logic                     done_o,
    input  logic [PORT_W-1:0]        port_in_i,
    output logic [PORT_W-1:0]        port_sample_o,
    input  logic                     port_we_i,
    input  logic [PORT_W-1:0]        port_wdata_i,
    output logic [PORT_W-1:0]        port_out_o
);

    logic [PH_W-1:0] phase;
    logic            last;

    xbus_phase_gen u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_o (phase),
        .last_o  (last)
    );

    xbus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .last_i       (last),
        .req_i        (req_i),
        .req_we_i     (req_we_i),
        .req_addr_i   (req_addr_i),
        .req_wdata_i  (req_wdata_i),
        .ad_in_i      (ad_in_i),
        .ale_o        (ale_o),
        .rd_n_o       (rd_n_o),
        .wr_n_o       (wr_n_o),
        .ad_out_o     (ad_out_o),
        .ad_oe_o      (ad_oe_o),
        .addr_hi_o    (addr_hi_o),
        .addr_hi_oe_o (addr_hi_oe_o),
        .rdata_o      (rdata_o),
        .done_o       (done_o)
    );

    xbus_port_unit #(
        .PORT_W (PORT_W)
    ) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_i       (phase),
        .port_in_i     (port_in_i),
        .port_we_i     (port_we_i),
        .port_wdata_i  (port_wdata_i),
        .port_sample_o (port_sample_o),
        .port_out_o    (port_out_o)
    );

endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        req_we_i = 1'b0;
    logic [15:0] req_addr_i = '0;
    logic [7:0]  req_wdata_i = '0;
    logic [7:0]  ad_in_i = '0;
    logic [7:0]  ad_out_o;
    logic        ad_oe_o;
    logic [7:0]  addr_hi_o;
    logic        addr_hi_oe_o;
    logic        ale_o, rd_n_o, wr_n_o, done_o;
    logic [7:0]  rdata_o;
    logic [7:0]  port_in_i = '0;
    logic [7:0]  port_sample_o;
    logic        port_we_i = 1'b0;
    logic [7:0]  port_wdata_i = '0;
    logic [7:0]  port_out_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    int ph = 0;

    always #5 clk = ~clk;

    // Bench model of the phase index (R2): 0 on first clock after reset.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= 0;
        else        ph <= (ph == 11) ? 0 : ph + 1;
    end

    xbus_seq dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .req_we_i(req_we_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
        .ad_in_i(ad_in_i), .ad_out_o(ad_out_o), .ad_oe_o(ad_oe_o),
        .addr_hi_o(addr_hi_o), .addr_hi_oe_o(addr_hi_oe_o),
        .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o),
        .rdata_o(rdata_o), .done_o(done_o),
        .port_in_i(port_in_i), .port_sample_o(port_sample_o),
        .port_we_i(port_we_i), .port_wdata_i(port_wdata_i), .port_out_o(port_out_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected per-phase traces (bit k = phase k)
    function automatic logic [11:0] exp_ale();          return 12'h003; endfunction
    function automatic logic [11:0] exp_oe(bit we);     return we ? 12'hFFF : 12'h007; endfunction
    function automatic logic [11:0] exp_stb(bit act);   return act ? 12'h7E0 : 12'h000; endfunction
    function automatic logic [11:0] exp_done();         return 12'h800; endfunction
    function automatic logic [7:0]  exp_out(bit we, int k, logic [15:0] a, logic [7:0] d);
        return (k < 3) ? a[7:0] : d;
    endfunction

    // dup: 0 none, 1 extra request while pending, 2 extra request during cycle
    task automatic run_txn(input bit we, input logic [15:0] addr, input logic [7:0] wd,
                           input logic [7:0] rv, input int lp, input int dup);
        logic [11:0] t_ale, t_oe, t_rd, t_wr, t_done, t_hi;
        int bad_val, bad_hi, idle_bad, waited, exp_wait;
        t_ale = '0; t_oe = '0; t_rd = '0; t_wr = '0; t_done = '0; t_hi = '0;
        bad_val = 0; bad_hi = 0; idle_bad = 0; waited = 0;
        while (ph != lp) @(negedge clk);
        req_i = 1'b1; req_we_i = we; req_addr_i = addr; req_wdata_i = wd;
        @(negedge clk);
        req_i = 1'b0;
        exp_wait = (lp == 11) ? 0 : 11 - lp;
        while (ph != 0) begin
            if (addr_hi_oe_o || ale_o || ad_oe_o) idle_bad++;
            if (dup == 1 && waited == 0) begin
                req_i = 1'b1; req_we_i = !we; req_addr_i = ~addr; req_wdata_i = ~wd;
            end else begin
                req_i = 1'b0;
            end
            waited++;
            @(negedge clk);
        end
        req_i = 1'b0; req_we_i = we; req_addr_i = addr; req_wdata_i = wd;
        chk(idle_bad == 0 && waited == exp_wait, "R2", "wait before cycle", waited, exp_wait);
        for (int k = 0; k < 12; k++) begin
            ad_in_i = (k >= 7 && k <= 10) ? rv : 8'($urandom);
            if (dup == 2 && k == 4) begin
                req_i = 1'b1; req_we_i = !we; req_addr_i = ~addr;
            end else begin
                req_i = 1'b0;
            end
            t_ale[k] = ale_o; t_oe[k] = ad_oe_o; t_rd[k] = !rd_n_o; t_wr[k] = !wr_n_o;
            t_done[k] = done_o; t_hi[k] = addr_hi_oe_o;
            if (ad_oe_o && ad_out_o != exp_out(we, k, addr, wd)) bad_val++;
            if (addr_hi_o != addr[15:8]) bad_hi++;
            if (k == 11 && !we)
                chk(rdata_o == rv, "R6", "captured read byte", rdata_o, rv);
            @(negedge clk);
        end
        req_i = 1'b0;
        chk(t_ale == exp_ale(), "R3", "ale trace", t_ale, exp_ale());
        chk(t_oe == exp_oe(we), we ? "R8" : "R6", "bus enable trace", t_oe, exp_oe(we));
        chk(bad_val == 0, we ? "R8" : "R3", "bus byte mismatches", bad_val, 0);
        chk(t_hi == 12'hFFF && bad_hi == 0, "R4", "high address", {t_hi, 8'(bad_hi)}, {12'hFFF, 8'h0});
        chk(t_rd == exp_stb(!we), "R5", "rd low trace", t_rd, exp_stb(!we));
        chk(t_wr == exp_stb(we), "R7", "wr low trace", t_wr, exp_stb(we));
        chk((t_rd & t_wr) == 0 && (t_ale & (t_rd | t_wr)) == 0, "R9", "strobe overlap", t_rd & t_wr, 0);
        chk(t_done == exp_done(), "R10", "done trace", t_done, exp_done());
        if (dup != 0) begin
            idle_bad = 0;
            for (int k = 0; k < 12; k++) begin
                if (addr_hi_oe_o || ale_o || !rd_n_o || !wr_n_o) idle_bad++;
                @(negedge clk);
            end
            chk(idle_bad == 0, "R11", "dropped request caused a cycle", idle_bad, 0);
        end
    endtask

    task automatic port_test(input int cycles);
        logic [7:0] prev, at9, v_old, v_new;
        int wph, bad;
        while (ph != 0) @(negedge clk);
        prev = port_sample_o;
        at9 = prev;
        for (int k = 0; k < cycles * 12; k++) begin
            if (ph == 10) begin
                chk(port_sample_o == at9, "R12", "sample after phase 9", port_sample_o, at9);
                prev = at9;
            end
            if (ph == 9) begin
                chk(port_sample_o == prev, "R12", "no early sample", port_sample_o, prev);
                at9 = 8'($urandom);
                port_in_i = at9;
            end else begin
                port_in_i = 8'($urandom);
            end
            @(negedge clk);
        end
        for (int n = 0; n < 4; n++) begin
            v_old = port_out_o;
            v_new = 8'($urandom);
            wph = (n == 0) ? 11 : (n == 1) ? 0 : int'($urandom_range(0, 11));
            while (ph != wph) @(negedge clk);
            port_we_i = 1'b1; port_wdata_i = v_new;
            @(negedge clk);
            port_we_i = 1'b0; port_wdata_i = ~v_new;
            bad = 0;
            while (ph != 0) begin
                if (port_out_o != v_old) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R13", "port out changed early", bad, 0);
            chk(port_out_o == v_new, "R13", "port out after phase 11", port_out_o, v_new);
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(rd_n_o && wr_n_o && !ale_o && !ad_oe_o && !addr_hi_oe_o && !done_o && port_out_o == 0,
            "R1", "reset outputs",
            {rd_n_o, wr_n_o, ale_o, ad_oe_o, addr_hi_oe_o, done_o, port_out_o},
            {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00});
        rst_n = 1'b1;
        @(negedge clk);
        chk(ph == 1 && !addr_hi_oe_o, "R2", "idle after reset", addr_hi_oe_o, 0);

        // Directed corners
        run_txn(1'b0, 16'hA55A, 8'h00, 8'hC3, 11, 0); // immediate start
        run_txn(1'b1, 16'h1234, 8'h7E, 8'h00, 0, 0);  // longest wait
        run_txn(1'b0, 16'hFFFF, 8'h00, 8'h00, 10, 1); // dropped while pending
        run_txn(1'b1, 16'h0001, 8'hFF, 8'h00, 3, 2);  // dropped during cycle
        run_txn(1'b0, 16'h8000, 8'h00, 8'hFF, 5, 2);

        // Random traffic
        for (int i = 0; i < 24; i++) begin
            run_txn(1'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                    int'($urandom_range(0, 11)), 0);
        end

        port_test(4);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule